// File: doc/BRIEF.md
# Parallel Digital Video Field Sync Marker

This block watches a bit-parallel 4:2:2 component video word stream, carried at one word per clock. It numbers every word of the line and raises a one-clock strobe on the word that marks the synchronization point of field 1 or field 2. The sync points sit at fixed positions inside particular lines, chosen to match the analog field timing. They are not at the line start and not at the timing reference codes.

Upstream logic has already found the timing codes and recovered the line number. That logic flags the first word of each line (the end-of-active-video code word), presents the line number with it, and selects the 525-line or 625-line standard. Words follow the order Cb, Y, Cr, Y, so luma sample n is word 2n+1.

Control is a four-state machine:
- HUNT: waits for the first line start after reset.
- BLANK: covers the words from the line start up to the wrap point.
- PICTURE: covers the words from index 0 up to the next line start.
- COAST: is entered when a line start goes missing. Counting carries on but no strobe fires.

The transitions are:
- SYNC: a line start, from any state, goes to BLANK.
- WRAP: BLANK goes to PICTURE as the index wraps to 0.
- MISS: PICTURE goes to COAST when the index passes 1439 with no line start.

Top module: `vsm_field_sync`

## Requirements
- R1: After reset `word_idx` is 0 and both strobes are low. Until the first valid word with `line_start` high, valid words leave `word_idx` at 0 and raise no strobe.
- R2: A valid word with `line_start` high gets index 1440. That index appears on `word_idx` one clock later, together with the strobe decision for that word.
- R3: Each later valid word takes the previous index plus one. On a cycle with `word_valid` low, `word_idx` holds, both strobes are low, and `line_start`, `line_num` and `std_sel` are ignored.
- R4: With `std_sel`=0 (525 lines) the index wraps from 1715 to 0, giving 1716 words per line.
- R5: With `std_sel`=1 (625 lines) the index wraps from 1727 to 0, giving 1728 words per line.
- R6: In 525 mode `field1_strobe` fires for word 1473 (luma sample 736) of line 4.
- R7: In 525 mode `field2_strobe` fires for word 615 (luma sample 307) of line 266.
- R8: In 625 mode `field1_strobe` fires for word 1465 (luma sample 732) of line 1.
- R9: In 625 mode `field2_strobe` fires for word 601 (luma sample 300) of line 313.
- R10: `std_sel` is sampled only on the line-start word. A change elsewhere takes effect at the next line start.
- R11: `line_num` is sampled only on the line-start word. Lines other than the four target lines produce no strobe.
- R12: If the index passes from 1439 to 1440 without a line start, counting continues but no strobe fires until the next line start.
- R13: Each strobe is high for a single clock, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid | input | 1 | A video word is present this cycle |
| line_start | input | 1 | This valid word is the first (timing code) word of a line |
| line_num | input | 10 | Line number, 1-based, sampled with `line_start` |
| std_sel | input | 1 | 0 = 525-line, 1 = 625-line, sampled with `line_start` |
| field1_strobe | output | 1 | Field 1 sync point word, one clock late |
| field2_strobe | output | 1 | Field 2 sync point word, one clock late |
| word_idx | output | 11 | Index of the most recent valid word |

## Verification
The bench puts gaps into every line, and drives `line_start` and junk line numbers during those gaps. A design that let idle cycles advance the index, or that resynchronised on an unqualified `line_start`, would move the strobe off its word.

The bench flips `std_sel` and `line_num` in the middle of a line. A design that used the live inputs instead of the values latched at the line start would wrap at the wrong count or fire on the wrong line.

It lets a line run past its end with no line start. A design that kept firing while free-running would strobe a second time at word 1473.

It also runs the 525 and 625 targets, whose word positions differ by only 8 or 14. Swapping or miscomputing the luma-to-word mapping would show up as an off-position strobe.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

    localparam int IDX_W   = 11;
    localparam int LINE_W  = 10;
    localparam int NUM_STD = 2;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_BLANK   = 2'd1,
        ST_PICTURE = 2'd2,
        ST_COAST   = 2'd3
    } sync_state_t;

    typedef struct packed {
        logic [IDX_W-1:0]  last_word;
        logic [IDX_W-1:0]  f1_word;
        logic [LINE_W-1:0] f1_line;
        logic [IDX_W-1:0]  f2_word;
        logic [LINE_W-1:0] f2_line;
    } std_profile_t;

endpackage

// File: rtl/vsm_std_table.sv
module vsm_std_table
    import vsm_pkg::*;
#(
    parameter int LINE_WORDS [NUM_STD] = '{1716, 1728},
    parameter int F1_Y       [NUM_STD] = '{736, 732},
    parameter int F1_LINE    [NUM_STD] = '{4, 1},
    parameter int F2_Y       [NUM_STD] = '{307, 300},
    parameter int F2_LINE    [NUM_STD] = '{266, 313}
) (
    input  logic         std_sel,
    output std_profile_t prof
);

    std_profile_t tbl [NUM_STD];

    // Luma sample n travels as word 2n+1 in Cb,Y,Cr,Y order.
    for (genvar g = 0; g < NUM_STD; g++) begin : g_std
        assign tbl[g] = std_profile_t'{
            last_word: IDX_W'(LINE_WORDS[g] - 1),
            f1_word:   IDX_W'(2 * F1_Y[g] + 1),
            f1_line:   LINE_W'(F1_LINE[g]),
            f2_word:   IDX_W'(2 * F2_Y[g] + 1),
            f2_line:   LINE_W'(F2_LINE[g])
        };
    end

    assign prof = tbl[std_sel];

endmodule

// File: rtl/vsm_word_tracker.sv
module vsm_word_tracker
    import vsm_pkg::*;
#(
    parameter int EAV_WORD = 1440
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              std_sel,
    input  logic              run,
    input  logic [IDX_W-1:0]  last_word,
    output logic              std_cur,
    output logic [LINE_W-1:0] line_cur,
    output logic [IDX_W-1:0]  idx_cur,
    output logic [IDX_W-1:0]  idx_q
);

    localparam logic [IDX_W-1:0] EAV_IDX = IDX_W'(EAV_WORD);

    logic              std_q;
    logic [LINE_W-1:0] line_q;

    // Standard and line number: taken only from the line-start word.
    always_comb begin
        std_cur  = std_q;
        line_cur = line_q;
        if (line_start) begin
            std_cur  = std_sel;
            line_cur = line_num;
        end
    end

    // Word index of the word presented this cycle.
    always_comb begin
        idx_cur = idx_q;
        if (line_start) begin
            idx_cur = EAV_IDX;
        end else if (run) begin
            idx_cur = (idx_q == last_word) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            std_q  <= 1'b0;
            line_q <= '0;
            idx_q  <= '0;
        end else if (word_valid) begin
            std_q  <= std_cur;
            line_q <= line_cur;
            idx_q  <= idx_cur;
        end
    end

endmodule

// File: rtl/vsm_sync_fsm.sv
module vsm_sync_fsm
    import vsm_pkg::*;
#(
    parameter int EAV_WORD = 1440
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_valid,
    input  logic             line_start,
    input  logic [IDX_W-1:0] idx_q,
    input  logic [IDX_W-1:0] last_word,
    output logic             run,
    output logic             track_en
);

    localparam logic [IDX_W-1:0] PIC_LAST = IDX_W'(EAV_WORD - 1);

    sync_state_t state_q;
    sync_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state_q;
        if (word_valid) begin
            if (line_start) begin
                state_nxt = ST_BLANK;                    // SYNC
            end else begin
                unique case (state_q)
                    ST_HUNT:    state_nxt = ST_HUNT;
                    ST_BLANK:   if (idx_q == last_word)  // WRAP
                                    state_nxt = ST_PICTURE;
                    ST_PICTURE: if (idx_q == PIC_LAST)   // MISS
                                    state_nxt = ST_COAST;
                    ST_COAST:   state_nxt = ST_COAST;
                endcase
            end
        end
    end

    always_comb begin
        run      = (state_q != ST_HUNT);
        track_en = word_valid &&
                   ((state_nxt == ST_BLANK) || (state_nxt == ST_PICTURE));
    end

endmodule

// File: rtl/vsm_strobe_gen.sv
module vsm_strobe_gen
    import vsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track_en,
    input  logic [IDX_W-1:0]  idx_cur,
    input  logic [LINE_W-1:0] line_cur,
    input  logic [IDX_W-1:0]  f1_word,
    input  logic [LINE_W-1:0] f1_line,
    input  logic [IDX_W-1:0]  f2_word,
    input  logic [LINE_W-1:0] f2_line,
    output logic              field1_strobe,
    output logic              field2_strobe
);

    logic hit1;
    logic hit2;

    always_comb begin
        hit1 = track_en && (idx_cur == f1_word) && (line_cur == f1_line);
        hit2 = track_en && (idx_cur == f2_word) && (line_cur == f2_line);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field1_strobe <= 1'b0;
            field2_strobe <= 1'b0;
        end else begin
            field1_strobe <= hit1;
            field2_strobe <= hit2;
        end
    end

endmodule

// File: rtl/vsm_field_sync.sv
module vsm_field_sync
    import vsm_pkg::*;
#(
    parameter int EAV_WORD             = 1440,
    parameter int LINE_WORDS [NUM_STD] = '{1716, 1728},
    parameter int F1_Y       [NUM_STD] = '{736, 732},
    parameter int F1_LINE    [NUM_STD] = '{4, 1},
    parameter int F2_Y       [NUM_STD] = '{307, 300},
    parameter int F2_LINE    [NUM_STD] = '{266, 313}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              std_sel,
    output logic              field1_strobe,
    output logic              field2_strobe,
    output logic [IDX_W-1:0]  word_idx
);

    std_profile_t      prof;
    logic              std_cur;
    logic [LINE_W-1:0] line_cur;
    logic [IDX_W-1:0]  idx_cur;
    logic [IDX_W-1:0]  idx_q;
    logic              run;
    logic              track_en;

    vsm_std_table #(
        .LINE_WORDS (LINE_WORDS),
        .F1_Y       (F1_Y),
        .F1_LINE    (F1_LINE),
        .F2_Y       (F2_Y),
        .F2_LINE    (F2_LINE)
    ) u_table (
        .std_sel (std_cur),
        .prof    (prof)
    );

    vsm_word_tracker #(.EAV_WORD(EAV_WORD)) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .line_start (line_start),
        .line_num   (line_num),
        .std_sel    (std_sel),
        .run        (run),
        .last_word  (prof.last_word),
        .std_cur    (std_cur),
        .line_cur   (line_cur),
        .idx_cur    (idx_cur),
        .idx_q      (idx_q)
    );

    vsm_sync_fsm #(.EAV_WORD(EAV_WORD)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .line_start (line_start),
        .idx_q      (idx_q),
        .last_word  (prof.last_word),
        .run        (run),
        .track_en   (track_en)
    );

    vsm_strobe_gen u_strobe (
        .clk           (clk),
        .rst_n         (rst_n),
        .track_en      (track_en),
        .idx_cur       (idx_cur),
        .line_cur      (line_cur),
        .f1_word       (prof.f1_word),
        .f1_line       (prof.f1_line),
        .f2_word       (prof.f2_word),
        .f2_line       (prof.f2_line),
        .field1_strobe (field1_strobe),
        .field2_strobe (field2_strobe)
    );

    assign word_idx = idx_q;

endmodule

// File: rtl/vsm_field_sync_checker.sv
module vsm_field_sync_checker
    import vsm_pkg::*;
#(
    parameter int EAV_WORD = 1440,
    parameter int MAX_WORD = 1727,
    parameter int F1_A     = 1473,
    parameter int F1_B     = 1465,
    parameter int F2_A     = 615,
    parameter int F2_B     = 601
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_valid,
    input logic             line_start,
    input logic             field1_strobe,
    input logic             field2_strobe,
    input logic [IDX_W-1:0] word_idx
);

    localparam logic [IDX_W-1:0] EAV_IDX = IDX_W'(EAV_WORD);
    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(MAX_WORD);
    localparam logic [IDX_W-1:0] F1A_IDX = IDX_W'(F1_A);
    localparam logic [IDX_W-1:0] F1B_IDX = IDX_W'(F1_B);
    localparam logic [IDX_W-1:0] F2A_IDX = IDX_W'(F2_A);
    localparam logic [IDX_W-1:0] F2B_IDX = IDX_W'(F2_B);

    a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(field1_strobe && field2_strobe));

    a_r13_f1_single: assert property (@(posedge clk) disable iff (!rst_n)
        field1_strobe |=> !field1_strobe);

    a_r13_f2_single: assert property (@(posedge clk) disable iff (!rst_n)
        field2_strobe |=> !field2_strobe);

    a_r2_eav_index: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && line_start) |=> (word_idx == EAV_IDX));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> ($stable(word_idx) && !field1_strobe && !field2_strobe));

    // R6 and R8: field 1 only on one of its two target words
    a_r6_f1_position: assert property (@(posedge clk) disable iff (!rst_n)
        field1_strobe |-> ((word_idx == F1A_IDX) || (word_idx == F1B_IDX)));

    // R7 and R9: field 2 only on one of its two target words
    a_r7_f2_position: assert property (@(posedge clk) disable iff (!rst_n)
        field2_strobe |-> ((word_idx == F2A_IDX) || (word_idx == F2B_IDX)));

    // R4 and R5: index never beyond the longer line
    a_r5_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        word_idx <= MAX_IDX);

endmodule

bind vsm_field_sync vsm_field_sync_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_valid    (word_valid),
    .line_start    (line_start),
    .field1_strobe (field1_strobe),
    .field2_strobe (field2_strobe),
    .word_idx      (word_idx)
);

// File: tb/tb_vsm_field_sync.sv
`timescale 1ns/1ps
module tb_vsm_field_sync;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic        line_start = 1'b0;
    logic [9:0]  line_num = '0;
    logic        std_sel = 1'b0;
    logic        field1_strobe;
    logic        field2_strobe;
    logic [10:0] word_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit m_hunt = 1, m_coast = 0, m_std = 0;
    int m_idx = 0, m_line = 0;
    bit e1 = 0, e2 = 0;
    string phase = "R1";
    int seen_f1, seen_f2, f1_at, f2_at;

    always #5 clk = ~clk;

    vsm_field_sync dut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .line_start(line_start),
        .line_num(line_num), .std_sel(std_sel), .field1_strobe(field1_strobe),
        .field2_strobe(field2_strobe), .word_idx(word_idx)
    );

    function automatic int lastw(bit s);  return s ? 1727 : 1715; endfunction
    function automatic int f1w(bit s);    return s ? 1465 : 1473; endfunction
    function automatic int f1l(bit s);    return s ? 1 : 4;       endfunction
    function automatic int f2w(bit s);    return s ? 601 : 615;   endfunction
    function automatic int f2l(bit s);    return s ? 313 : 266;   endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(bit v, bit ls, int ln, bit sd);
        string tag;
        word_valid = v; line_start = ls; line_num = 10'(ln); std_sel = sd;
        @(posedge clk);
        if (v) begin
            if (ls) begin
                m_idx = 1440; m_std = sd; m_line = ln; m_hunt = 0; m_coast = 0;
            end else if (!m_hunt) begin
                if (m_idx == 1439) m_coast = 1;
                m_idx = (m_idx == lastw(m_std)) ? 0 : m_idx + 1;
            end
            e1 = !m_hunt && !m_coast && m_idx == f1w(m_std) && m_line == f1l(m_std);
            e2 = !m_hunt && !m_coast && m_idx == f2w(m_std) && m_line == f2l(m_std);
        end else begin
            e1 = 0; e2 = 0;
        end
        #1;
        tag = v ? phase : "R3";
        chk(word_idx == 11'(m_idx), tag, "word_idx", int'(word_idx), m_idx);
        chk(field1_strobe == e1, tag, "field1_strobe", int'(field1_strobe), int'(e1));
        chk(field2_strobe == e2, tag, "field2_strobe", int'(field2_strobe), int'(e2));
        if (field1_strobe) begin seen_f1++; f1_at = int'(word_idx); end
        if (field2_strobe) begin seen_f2++; f2_at = int'(word_idx); end
    endtask

    // First word carries ln/sd; remaining words drive ln_after/sd_after.
    task automatic run_line(int ln, bit sd, int nwords, int ln_after, bit sd_after);
        seen_f1 = 0; seen_f2 = 0; f1_at = -1; f2_at = -1;
        step(1, 1, ln, sd);
        chk(word_idx == 11'd1440, "R2", "index of line-start word", int'(word_idx), 1440);
        for (int i = 1; i < nwords; i++) begin
            if (i % 97 == 0) begin
                step(0, 1, 313, ~sd);
                step(0, 1, 1, sd);
            end
            step(1, 0, ln_after, sd_after);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(word_idx == 0, "R1", "reset word_idx", int'(word_idx), 0);
        chk(!field1_strobe && !field2_strobe, "R1", "reset strobes",
            int'(field1_strobe) + int'(field2_strobe), 0);
        rst_n = 1'b1;

        phase = "R1";
        for (int i = 0; i < 20; i++) step(1, 0, 4, 0);
        chk(word_idx == 0, "R1", "hunt word_idx", int'(word_idx), 0);

        phase = "R6";
        run_line(4, 0, 1716, 4, 0);
        chk(seen_f1 == 1 && f1_at == 1473, "R6", "525 field1 word", f1_at, 1473);
        chk(seen_f1 + seen_f2 == 1, "R13", "strobe cycles in line 4", seen_f1 + seen_f2, 1);
        chk(word_idx == 1439, "R4", "525 line end index after wrap", int'(word_idx), 1439);

        phase = "R7";
        run_line(266, 0, 1716, 266, 0);
        chk(seen_f2 == 1 && f2_at == 615, "R7", "525 field2 word", f2_at, 615);
        chk(seen_f1 == 0, "R13", "no field1 on line 266", seen_f1, 0);

        phase = "R11";
        run_line(5, 0, 1716, 266, 0);
        chk(seen_f1 + seen_f2 == 0, "R11", "strobes on line 5", seen_f1 + seen_f2, 0);
        run_line(266, 0, 1716, 5, 0);
        chk(seen_f2 == 1 && f2_at == 615, "R11", "line change mid-line ignored", f2_at, 615);

        phase = "R8";
        run_line(1, 1, 1728, 1, 1);
        chk(seen_f1 == 1 && f1_at == 1465, "R8", "625 field1 word", f1_at, 1465);
        chk(word_idx == 1439, "R5", "625 line end index after wrap", int'(word_idx), 1439);

        phase = "R9";
        run_line(313, 1, 1728, 313, 1);
        chk(seen_f2 == 1 && f2_at == 601, "R9", "625 field2 word", f2_at, 601);

        phase = "R10";
        run_line(4, 0, 1716, 4, 1);
        chk(seen_f1 == 1 && f1_at == 1473, "R10", "std change mid-line ignored", f1_at, 1473);
        chk(word_idx == 1439, "R10", "525 wrap kept", int'(word_idx), 1439);
        run_line(313, 1, 1728, 313, 0);
        chk(seen_f2 == 1 && f2_at == 601, "R10", "new std at next line start", f2_at, 601);

        phase = "R12";
        run_line(4, 0, 1716, 4, 0);
        seen_f1 = 0; seen_f2 = 0;
        for (int i = 0; i < 1800; i++) step(1, 0, 4, 0);
        chk(seen_f1 + seen_f2 == 0, "R12", "strobes while coasting", seen_f1 + seen_f2, 0);
        chk(word_idx == 1523, "R12", "coast index", int'(word_idx), 1523);
        run_line(4, 0, 1716, 4, 0);
        chk(seen_f1 == 1 && f1_at == 1473, "R12", "strobe after resync", f1_at, 1473);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule